// File: doc/BRIEF.md
# Decoded RAM/ROM Memory Subsystem

This block is a small byte-wide memory system that sits on a processor-style bus. Behind one address decoder it holds four 128-byte RAM banks and one 512-byte read-only table. Every device sees the same read and write strobes and the same write data. Only its pair of chip selects differs: one select is active high and one is active low. A device responds only when its high select is 1 and its low select is 0.

The decoder uses address bit 9 to choose between the table (bit 9 = 1) and the RAM (bit 9 = 0). In RAM space, bits 8:7 pick one of the four banks. Bits 6:0 give the byte inside a bank, and bits 8:0 give the byte inside the table. Bits above 9 are not decoded, so the 1 KB map repeats across the whole 16-bit space.

A read drives the addressed byte out combinationally and raises an output-enable. The output-enable stands in for the release of a high-impedance bus. A RAM write takes effect on the rising clock edge. A one-hot device-select vector is brought out so that the decode can be observed.

The bus strobes are plain level controls with no handshake. A read completes in the cycle it is presented. A write completes at the next rising edge. The block never stalls the bus.

Top module: `mem_sys_top`

## Requirements
- R1: `dev_sel` is always one-hot. When `cpu_addr[9]`=1, `dev_sel[4]` (the table) is set. Otherwise `dev_sel[n]` is set, where n = `cpu_addr[8:7]` (bank 0 covers 0x000-0x07F and bank 3 covers 0x180-0x1FF).
- R2: Address bits 15:10 are ignored. Any two addresses that agree in bits 9:0 reach the same device and the same byte.
- R3: When the address is in RAM space, `cpu_rd`=0 and `cpu_wr`=1, the byte on `cpu_wdata` is stored at byte `cpu_addr[6:0]` of the selected bank on the rising clock edge. A later read returns that byte.
- R4: When `cpu_rd`=1, the selected device drives its addressed byte, `cpu_oe`=1, and no RAM location changes, even if `cpu_wr`=1.
- R5: When `cpu_rd`=0, `cpu_oe`=0 and `cpu_rdata`=0x00, whatever the value of `cpu_wr`.
- R6: A read with `cpu_addr[9]`=1 returns the table byte for a = `cpu_addr[8:0]`. That byte is ((a mod 256)*29 + (a div 256)*113) mod 256.
- R7: A write aimed at table space has no effect. A later read of that address still returns the R6 value.
- R8: A write changes only the one addressed byte of the one selected bank. Every other RAM byte keeps its value.
- R9: While `rst_n`=0, every RAM byte is cleared to 0x00 and writes are blocked. After reset, every RAM byte reads 0x00 until it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; RAM writes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears the RAM |
| cpu_addr | input | 16 | Byte address from the bus |
| cpu_wdata | input | 8 | Write data |
| cpu_rd | input | 1 | Read strobe; has priority over write |
| cpu_wr | input | 1 | Write strobe |
| cpu_rdata | output | 8 | Read data; 0x00 while `cpu_oe` is low |
| cpu_oe | output | 1 | High when exactly one device drives the bus |
| dev_sel | output | 5 | One-hot enabled device: bits 3:0 are the RAM banks, bit 4 is the table |

## Verification
The assertions check, on every cycle, that one device is enabled and that a read always turns on exactly one driver. They also check that the bus is quiet whenever no read is asserted, that a RAM write lands in the addressed byte on the next edge, and that a read with a write strobe leaves the RAM untouched. Some behaviours need history and a reference model, and only the bench's scenarios can show them. These are the table contents, the aliasing of the upper address bits, the isolation between banks, the rejection of writes into table space, and the clearing and write-blocking done by reset.

// File: rtl/mem_sys_pkg.sv
package mem_sys_pkg;

  typedef struct packed {
    logic sel_hi;
    logic sel_lo_n;
  } chip_sel_t;

  function automatic logic cs_enabled(chip_sel_t cs);
    return cs.sel_hi & ~cs.sel_lo_n;
  endfunction

  localparam int unsigned TBL_MUL_LO = 29;
  localparam int unsigned TBL_MUL_HI = 113;

endpackage

// File: rtl/mem_addr_decoder.sv
module mem_addr_decoder
  import mem_sys_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int RAM_AW = 7,
  parameter int BANK_W = 2,
  localparam int BANKS  = 1 << BANK_W,
  localparam int ROM_AW = RAM_AW + BANK_W
) (
  input  logic [ADDR_W-1:0] addr,
  output chip_sel_t         ram_cs [BANKS],
  output chip_sel_t         rom_cs
);

  logic              region_rom;
  logic [BANK_W-1:0] bank_idx;
  logic [BANKS-1:0]  bank_hit;
  logic              unused_hi;

  assign region_rom = addr[ROM_AW];
  assign bank_idx   = addr[RAM_AW +: BANK_W];
  assign unused_hi  = ^addr[ADDR_W-1:ROM_AW+1];

  always_comb begin
    bank_hit = '0;
    bank_hit[bank_idx] = 1'b1;
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank_cs
    assign ram_cs[b].sel_hi   = bank_hit[b];
    assign ram_cs[b].sel_lo_n = region_rom;
  end

  assign rom_cs.sel_hi   = region_rom;
  assign rom_cs.sel_lo_n = ~region_rom;

endmodule

// File: rtl/mem_ram_bank.sv
module mem_ram_bank
  import mem_sys_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  chip_sel_t     cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          drive
);

  logic [DW-1:0] mem [DEPTH];
  logic          enabled;
  logic          wen;

  assign enabled = cs_enabled(cs);
  assign drive   = enabled & rd;
  assign wen     = enabled & ~rd & wr;
  assign rdata   = drive ? mem[addr] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wen) begin
      mem[addr] <= wdata;
    end
  end

  // R3: a write strobe without read stores the byte at the next edge
  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && !rd && wr) |=> mem[$past(addr)] == $past(wdata));

  // R4: read with write strobe leaves the addressed byte unchanged
  assert_read_blocks_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && rd && wr) |=> mem[$past(addr)] == $past(mem[addr]));

endmodule

// File: rtl/mem_rom_table.sv
module mem_rom_table
  import mem_sys_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  chip_sel_t     cs,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] rdata,
  output logic          drive
);

  logic [31:0] a32;
  logic [31:0] val;

  assign a32   = 32'(addr);
  assign val   = (a32 & 32'hFF) * TBL_MUL_LO + (a32 >> 8) * TBL_MUL_HI;
  assign drive = cs_enabled(cs) & rd;
  assign rdata = drive ? val[DW-1:0] : '0;

endmodule

// File: rtl/mem_sys_top.sv
module mem_sys_top
  import mem_sys_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RAM_AW = 7,
  parameter int BANK_W = 2,
  localparam int BANKS  = 1 << BANK_W,
  localparam int ROM_AW = RAM_AW + BANK_W,
  localparam int NDEV   = BANKS + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_oe,
  output logic [NDEV-1:0]   dev_sel
);

  chip_sel_t         ram_cs [BANKS];
  chip_sel_t         rom_cs;
  logic [DATA_W-1:0] dev_data [NDEV];
  logic [NDEV-1:0]   dev_drive;
  logic [DATA_W-1:0] bus_or;
  logic              wr_gated;

  assign wr_gated = cpu_wr & rst_n;

  mem_addr_decoder #(
    .ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .BANK_W(BANK_W)
  ) u_dec (
    .addr  (cpu_addr),
    .ram_cs(ram_cs),
    .rom_cs(rom_cs)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    mem_ram_bank #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
      .clk  (clk),
      .rst_n(rst_n),
      .cs   (ram_cs[b]),
      .rd   (cpu_rd),
      .wr   (wr_gated),
      .addr (cpu_addr[RAM_AW-1:0]),
      .wdata(cpu_wdata),
      .rdata(dev_data[b]),
      .drive(dev_drive[b])
    );
    assign dev_sel[b] = cs_enabled(ram_cs[b]);
  end

  mem_rom_table #(.AW(ROM_AW), .DW(DATA_W)) u_rom (
    .cs   (rom_cs),
    .rd   (cpu_rd),
    .addr (cpu_addr[ROM_AW-1:0]),
    .rdata(dev_data[BANKS]),
    .drive(dev_drive[BANKS])
  );
  assign dev_sel[BANKS] = cs_enabled(rom_cs);

  always_comb begin
    bus_or = '0;
    for (int d = 0; d < NDEV; d++) bus_or = bus_or | dev_data[d];
  end

  assign cpu_oe    = ($countones(dev_drive) == 1);
  assign cpu_rdata = cpu_oe ? bus_or : '0;

  // R1: exactly one device enabled for every address
  assert_single_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dev_sel) == 1);

  // R4: a read always yields a driven bus
  assert_read_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd |-> cpu_oe);

  // R5: no read means quiet bus
  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |-> (!cpu_oe && cpu_rdata == '0));

  // R1: the driver is the selected device
  assert_driver_is_selected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_oe |-> (dev_drive == dev_sel));

endmodule

// File: tb/mem_sys_top_tb_top.sv
`timescale 1ns/1ps
module mem_sys_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_rdata;
  logic        cpu_oe;
  logic [4:0]  dev_sel;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] ram_m [512];

  always #5 clk = ~clk;

  mem_sys_top dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
    .cpu_oe(cpu_oe), .dev_sel(dev_sel)
  );

  function automatic logic [7:0] tbl_byte(int a);
    int lo = a & 255;
    int hi = (a >> 8) & 1;
    return 8'((lo * 29 + hi * 113) & 255);
  endfunction

  function automatic logic [4:0] exp_sel(logic [15:0] a);
    if (a[9]) return 5'b10000;
    return 5'(1 << a[8:7]);
  endfunction

  function automatic logic [7:0] exp_read(logic [15:0] a);
    if (a[9]) return tbl_byte(int'(a[8:0]));
    return ram_m[a[8:0]];
  endfunction

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
  endtask

  task automatic do_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_rd = 1'b0; cpu_wr = 1'b1;
    #2;
    check("R5 write quiet oe", int'(cpu_oe), 0);
    check("R1 write sel", int'(dev_sel), int'(exp_sel(a)));
    @(negedge clk);
    cpu_wr = 1'b0;
    if (!a[9]) ram_m[a[8:0]] = d;
  endtask

  task automatic do_read(logic [15:0] a, logic wr_too, string tag);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1; cpu_wr = wr_too; cpu_wdata = 8'($urandom);
    #2;
    check({tag, " oe R4"}, int'(cpu_oe), 1);
    check({tag, " data"}, int'(cpu_rdata), int'(exp_read(a)));
    check("R1 read sel", int'(dev_sel), int'(exp_sel(a)));
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    #2;
    check("R5 idle after read", int'(cpu_oe), 0);
    check("R5 idle data", int'(cpu_rdata), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 512; i++) ram_m[i] = 8'h00;

    // R9: reset state and write blocked during reset
    cpu_addr = 16'h0005; cpu_wdata = 8'hAA; cpu_wr = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset oe", int'(cpu_oe), 0);
    check("R9 reset data", int'(cpu_rdata), 0);
    cpu_wr = 1'b0;
    rst_n = 1'b1;
    do_read(16'h0005, 1'b0, "R9 cleared");
    do_read(16'h01FF, 1'b0, "R9 cleared");

    // R5: write strobe alone gives no output (checked inside do_write)
    // R3, R8: bank writes and isolation
    do_write(16'h0010, 8'h11);
    do_write(16'h0090, 8'h22);
    do_write(16'h0110, 8'h33);
    do_write(16'h0190, 8'h44);
    do_read(16'h0010, 1'b0, "R3 bank0");
    do_read(16'h0090, 1'b0, "R8 bank1");
    do_read(16'h0110, 1'b0, "R8 bank2");
    do_read(16'h0190, 1'b0, "R8 bank3");
    do_read(16'h0011, 1'b0, "R8 neighbour");

    // R4: read with write strobe does not write
    do_read(16'h0010, 1'b1, "R4 rd+wr");
    do_read(16'h0010, 1'b0, "R4 unchanged");

    // R2: aliasing of upper bits
    do_write(16'hFC05, 8'h5C);
    do_read(16'h0005, 1'b0, "R2 alias");
    do_read(16'h8405, 1'b0, "R2 alias");

    // R6, R7: table contents and ignored writes
    do_read(16'h0200, 1'b0, "R6 table");
    do_read(16'h03FF, 1'b0, "R6 table");
    do_write(16'h0234, 8'hFF);
    do_read(16'h0234, 1'b0, "R7 table write");
    do_read(16'h0034, 1'b0, "R7 ram shadow");

    // randomized mix
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      int op;
      a  = 16'($urandom);
      op = int'($urandom % 4);
      case (op)
        0: do_write(a, 8'($urandom));
        1: do_read(a, 1'b0, a[9] ? "R6 rand" : "R3 rand");
        2: do_read(a, 1'b1, "R4 rand");
        default: begin
          @(negedge clk);
          cpu_addr = a; cpu_rd = 1'b0; cpu_wr = 1'b0;
          #2;
          check("R5 rand idle", int'(cpu_oe), 0);
          check("R1 rand sel", int'(dev_sel), int'(exp_sel(a)));
        end
      endcase
    end

    // final sweep of RAM contents against model (R8)
    for (int k = 0; k < 512; k += 7) do_read(16'(k), 1'b0, "R8 sweep");

    summary();
    $finish;
  end

endmodule